// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block times one programmed-I/O data transfer on a parallel ATA channel. A host request picks one of four drives, a direction, and either the data port or the command block. The block then runs three phases in order. First comes address setup, with no strobe. Next comes the active phase, with the read or write strobe asserted. Last comes recovery, with the strobe released. The block flags completion on the final recovery clock.

The phase lengths come from byte-wide timing registers. Each primary drive has its own pair: an address timing register and a data timing register. The two secondary drives share a single pair. A separate command timing register times command-block accesses.

The address timing register carries a two-bit setup code in bits 7:6. Its low six bits are general control bits, and a setup-only write leaves them intact. The data timing register packs the active count in its upper nibble and the recovery count in its lower nibble. A chip-revision input lengthens recovery by one clock on later revisions.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, every timing register reads 0x00. busy, rd_stb, wr_stb and done are low. A drive cycle then uses 4 setup, 16 active and 16 recovery clocks.
- R2: The setup phase length is set by bits 7:6 of the address timing register. The codes are 00 = 4 clocks, 01 = 2 clocks, 10 = 3 clocks and 11 = 5 clocks.
- R3: reg_op 0 writes the whole address timing register. reg_op 1 writes only bits 7:6 and keeps bits 5:0. reg_op 2 writes the data timing register, and reg_op 3 writes the command timing register. reg_rdata returns the register that reg_op and reg_drv select, where ops 0 and 1 both read the address register.
- R4: In the data timing register, bits 7:4 hold the active count and bits 3:0 hold the recovery count. A nibble of 0 means 16 clocks.
- R5: The active phase lasts at least 2 clocks, so a programmed active count of 1 gives 2.
- R6: When the effective active length exceeds 3 and the recovery count is 1, recovery lasts 2 clocks.
- R7: When chip_rev is 2 or more, recovery lasts one clock more than the programmed count.
- R8: Drives 0 and 1 each use their own registers. Drives 2 and 3 read and write the same shared pair.
- R9: A request with req_cmd high takes active and recovery from the command timing register, with the same nibble rules, and always uses 4 setup clocks.
- R10: An accepted request gives busy for setup+active+recovery clocks. rd_stb (read) or wr_stb (write) is high only during the active phase. done is high on exactly the last recovery clock.
- R11: A request is accepted only when idle. Requests made while busy are ignored. Register writes made during a cycle do not change that cycle's phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_rev | input | REV_W | Chip revision code |
| reg_we | input | 1 | Timing register write enable |
| reg_op | input | 2 | Register access kind (address, setup-only, data, command) |
| reg_drv | input | 2 | Drive whose registers are accessed |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Selected register value |
| req | input | 1 | Transfer request, taken when idle |
| req_drv | input | 2 | Drive addressed by the request |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_cmd | input | 1 | Use command-block timing |
| busy | output | 1 | Cycle in progress |
| rd_stb | output | 1 | Read strobe, active phase |
| wr_stb | output | 1 | Write strobe, active phase |
| done | output | 1 | Final recovery clock |

## Verification
The bench builds the block with its default REV_W of 2 and FAST_REV of 2. This lets chip_rev reach both sides of the revision threshold. Recovery can therefore reach its 17-clock extreme, which is the widest value the phase counter must hold. A behavioural queue model predicts busy, strobes and done on every clock. It covers every setup code, the 0-means-16 nibbles, both stretch rules, the shared secondary set and command timing.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;
    localparam int CNT_W = 5;   // holds up to 17 clocks

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_e;
    typedef enum logic [1:0] {OP_ADDR, OP_SETUP, OP_DATA, OP_CMD} regop_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } lens_t;
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_timer_pkg::*;
#(
    parameter int N_SETS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_op,
    input  logic [1:0] reg_drv,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [1:0] req_drv,
    output logic [7:0] sel_addr,
    output logic [7:0] sel_data,
    output logic [7:0] cmd_tim
);
    localparam int IDX_W = $clog2(N_SETS);

    typedef struct packed {
        logic [N_SETS-1:0][7:0] addr;
        logic [N_SETS-1:0][7:0] data;
        logic [7:0]             cmd;
    } regs_t;

    regs_t r_d, r_q;

    // drives 2 and 3 fold onto the shared secondary set
    function automatic logic [IDX_W-1:0] set_of(input logic [1:0] drv);
        return drv[1] ? IDX_W'(2) : IDX_W'(drv[0]);
    endfunction

    logic [IDX_W-1:0] wr_set, rq_set;

    always_comb begin
        wr_set = set_of(reg_drv);
        rq_set = set_of(req_drv);
        r_d    = r_q;
        if (reg_we) begin
            unique case (regop_e'(reg_op))
                OP_ADDR:  r_d.addr[wr_set]      = reg_wdata;
                OP_SETUP: r_d.addr[wr_set][7:6] = reg_wdata[7:6];
                OP_DATA:  r_d.data[wr_set]      = reg_wdata;
                OP_CMD:   r_d.cmd               = reg_wdata;
            endcase
        end
        unique case (regop_e'(reg_op))
            OP_DATA: reg_rdata = r_q.data[wr_set];
            OP_CMD:  reg_rdata = r_q.cmd;
            default: reg_rdata = r_q.addr[wr_set];
        endcase
        sel_addr = r_q.addr[rq_set];
        sel_data = r_q.data[rq_set];
        cmd_tim  = r_q.cmd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pio_len_decode.sv
module pio_len_decode
    import pio_timer_pkg::*;
#(
    parameter int REV_W    = 2,
    parameter int FAST_REV = 2
) (
    input  logic [1:0]       setup_code,
    input  logic [7:0]       timing,
    input  logic             use_cmd,
    input  logic [REV_W-1:0] rev,
    output lens_t            lens
);
    function automatic logic [CNT_W-1:0] nib_len(input logic [3:0] n);
        return (n == 4'd0) ? CNT_W'(16) : CNT_W'(n);
    endfunction

    always_comb begin
        unique case (setup_code)
            2'b00:   lens.setup = CNT_W'(4);
            2'b10:   lens.setup = CNT_W'(3);
            2'b01:   lens.setup = CNT_W'(2);
            default: lens.setup = CNT_W'(5);
        endcase
        if (use_cmd) lens.setup = CNT_W'(4);

        lens.active = nib_len(timing[7:4]);
        if (lens.active == CNT_W'(1)) lens.active = CNT_W'(2);

        lens.recov = nib_len(timing[3:0]);
        if (lens.active > CNT_W'(3) && lens.recov == CNT_W'(1))
            lens.recov = CNT_W'(2);
        if (rev >= REV_W'(FAST_REV))
            lens.recov = lens.recov + CNT_W'(1);
    end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  logic  req_write,
    input  lens_t lens,
    output logic  busy,
    output logic  rd_stb,
    output logic  wr_stb,
    output logic  done
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] rec;
        logic             write;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: if (req) begin
                s_d.phase = PH_SETUP;
                s_d.cnt   = lens.setup - CNT_W'(1);
                s_d.act   = lens.active;
                s_d.rec   = lens.recov;
                s_d.write = req_write;
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_ACTIVE;
                    s_d.cnt   = s_q.act - CNT_W'(1);
                end else s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            PH_ACTIVE: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_RECOV;
                    s_d.cnt   = s_q.rec - CNT_W'(1);
                end else s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            PH_RECOV: begin
                if (s_q.cnt == '0) s_d.phase = PH_IDLE;
                else               s_d.cnt   = s_q.cnt - CNT_W'(1);
            end
        endcase
        busy   = (s_q.phase != PH_IDLE);
        rd_stb = (s_q.phase == PH_ACTIVE) && !s_q.write;
        wr_stb = (s_q.phase == PH_ACTIVE) &&  s_q.write;
        done   = (s_q.phase == PH_RECOV) && (s_q.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
    import pio_timer_pkg::*;
#(
    parameter int REV_W    = 2,
    parameter int FAST_REV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REV_W-1:0] chip_rev,
    input  logic             reg_we,
    input  logic [1:0]       reg_op,
    input  logic [1:0]       reg_drv,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             req,
    input  logic [1:0]       req_drv,
    input  logic             req_write,
    input  logic             req_cmd,
    output logic             busy,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic             done
);
    logic [7:0] sel_addr, sel_data, cmd_tim, timing;
    lens_t      lens;

    pio_timing_regs #(.N_SETS(3)) regs_i (
        .clk, .rst_n, .reg_we, .reg_op, .reg_drv, .reg_wdata, .reg_rdata,
        .req_drv, .sel_addr, .sel_data, .cmd_tim
    );

    assign timing = req_cmd ? cmd_tim : sel_data;

    pio_len_decode #(.REV_W(REV_W), .FAST_REV(FAST_REV)) dec_i (
        .setup_code(sel_addr[7:6]), .timing, .use_cmd(req_cmd),
        .rev(chip_rev), .lens
    );

    pio_phase_seq seq_i (
        .clk, .rst_n, .req, .req_write, .lens,
        .busy, .rd_stb, .wr_stb, .done
    );
endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic rd_stb,
    input logic wr_stb,
    input logic done
);
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_stb, wr_stb, done}));
    a_r10_strobe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> busy);
    a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r11_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r5_rd_min_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_stb) |=> rd_stb);
    a_r5_wr_min_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb) |=> wr_stb);
endmodule

bind pio_strobe_timer pio_strobe_timer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .done(done)
);

// File: tb/pio_strobe_timer_tb.sv
module pio_strobe_timer_tb_top;
    logic       clk = 0, rst_n = 0;
    logic [1:0] chip_rev = 0;
    logic       reg_we = 0;
    logic [1:0] reg_op = 0, reg_drv = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       req = 0, req_write = 0, req_cmd = 0;
    logic [1:0] req_drv = 0;
    logic       busy, rd_stb, wr_stb, done;

    pio_strobe_timer dut_i (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";

    // reference state
    int m_addr[3], m_data[3], m_cmd;
    logic [3:0] q[$];     // {busy, rd, wr, done}
    logic [3:0] cur = 0;

    function automatic int sidx(int d);
        return (d >= 2) ? 2 : d;
    endfunction

    function automatic int nib(int v);
        return (v == 0) ? 16 : v;
    endfunction

    task automatic push_cycle(int d, bit w, bit c);
        int s, a, r;
        int code = (m_addr[sidx(d)] >> 6) & 3;
        int t = c ? m_cmd : m_data[sidx(d)];
        s = (code == 0) ? 4 : (code == 2) ? 3 : (code == 1) ? 2 : 5;
        if (c) s = 4;
        a = nib((t >> 4) & 15); if (a == 1) a = 2;
        r = nib(t & 15);        if (a > 3 && r == 1) r = 2;
        if (chip_rev >= 2) r++;
        repeat (s) q.push_back(4'b1000);
        repeat (a) q.push_back(w ? 4'b1010 : 4'b1100);
        for (int i = 0; i < r; i++) q.push_back((i == r-1) ? 4'b1001 : 4'b1000);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q = {}; cur = 0; m_cmd = 0;
            for (int i = 0; i < 3; i++) begin m_addr[i] = 0; m_data[i] = 0; end
        end else begin
            if (!cur[3] && req) push_cycle(req_drv, req_write, req_cmd);
            cur = (q.size() > 0) ? q.pop_front() : 4'b0000;
            if (reg_we) begin
                case (reg_op)
                    0: m_addr[sidx(reg_drv)] = reg_wdata;
                    1: m_addr[sidx(reg_drv)] = (m_addr[sidx(reg_drv)] & 8'h3f) | (reg_wdata & 8'hc0);
                    2: m_data[sidx(reg_drv)] = reg_wdata;
                    default: m_cmd = reg_wdata;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ({busy, rd_stb, wr_stb, done} !== cur) begin
                errors++;
                $display("FAIL %s/R10 cycle %0d: got %b expected %b", cur_req, cyc,
                         {busy, rd_stb, wr_stb, done}, cur);
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) if (cyc == 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic wr_reg(int op, int d, int v);
        @(negedge clk);
        reg_we = 1; reg_op = 2'(op); reg_drv = 2'(d); reg_wdata = 8'(v);
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic chk_rd(int op, int d, int exp, string tag);
        @(negedge clk);
        reg_op = 2'(op); reg_drv = 2'(d);
        #1;
        checks++;
        if (reg_rdata !== 8'(exp)) begin
            errors++;
            $display("FAIL %s: rdata got %h expected %h", tag, reg_rdata, 8'(exp));
        end
    endtask

    task automatic run(int d, bit w, bit c, string tag);
        cur_req = tag;
        @(negedge clk);
        req = 1; req_drv = 2'(d); req_write = w; req_cmd = c;
        @(negedge clk);
        req = 0;
        while (cur[3]) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values and outputs
        checks++;
        if ({busy, rd_stb, wr_stb, done} !== 4'b0) begin
            errors++; $display("FAIL R1: outputs got %b expected 0000", {busy, rd_stb, wr_stb, done});
        end
        rst_n = 1;
        for (int d = 0; d < 4; d++) begin
            chk_rd(0, d, 0, "R1");
            chk_rd(2, d, 0, "R1");
        end
        chk_rd(3, 0, 0, "R1");
        run(0, 0, 0, "R1");
        run(3, 1, 0, "R1");
        run(0, 0, 1, "R9");            // cmd register 0 -> slowest
        // R3: setup-only write keeps low bits
        wr_reg(0, 0, 8'hff);
        chk_rd(0, 0, 8'hff, "R3");
        wr_reg(1, 0, 8'h80);
        chk_rd(1, 0, 8'hbf, "R3");
        chk_rd(0, 1, 8'h00, "R8");     // drive 1 untouched
        // R2: every setup code, short data timing
        wr_reg(2, 0, 8'h23);
        run(0, 0, 0, "R2");
        wr_reg(1, 0, 8'h40); run(0, 1, 0, "R2");
        wr_reg(1, 0, 8'h00); run(0, 0, 0, "R2");
        wr_reg(1, 0, 8'hc0); run(0, 1, 0, "R2");
        chk_rd(0, 0, 8'hff & 8'hff & 8'hff & 8'h3f | 8'hc0, "R3");
        // R4: nibble zero means 16
        wr_reg(2, 0, 8'h05); run(0, 0, 0, "R4");
        wr_reg(2, 0, 8'h70); run(0, 1, 0, "R4");
        // R5: active 1 -> 2
        wr_reg(2, 0, 8'h12); run(0, 0, 0, "R5");
        // R6: recovery stretch and its non-case
        wr_reg(2, 0, 8'h51); run(0, 1, 0, "R6");
        wr_reg(2, 0, 8'h31); run(0, 0, 0, "R6");
        wr_reg(2, 0, 8'h11); run(0, 0, 0, "R6");
        // R7: revision adds one recovery clock
        chip_rev = 2; run(0, 0, 0, "R7");
        wr_reg(2, 0, 8'h00); run(0, 1, 0, "R7");
        chip_rev = 3; wr_reg(2, 0, 8'h22); run(0, 0, 0, "R7");
        chip_rev = 1; run(0, 0, 0, "R7");
        // R8: shared secondary set, separate primary sets
        wr_reg(0, 2, 8'h40); wr_reg(2, 3, 8'h34);
        chk_rd(2, 2, 8'h34, "R8");
        chk_rd(0, 3, 8'h40, "R8");
        run(2, 0, 0, "R8");
        run(3, 1, 0, "R8");
        wr_reg(2, 1, 8'h23); run(1, 0, 0, "R8");
        run(0, 0, 0, "R8");
        // R9: command timing ignores setup code
        wr_reg(3, 0, 8'h32); chk_rd(3, 2, 8'h32, "R9");
        run(0, 1, 1, "R9");
        run(2, 0, 1, "R9");
        // R11: request while busy ignored; writes mid-cycle don't alter timing
        cur_req = "R11";
        @(negedge clk);
        req = 1; req_drv = 0; req_write = 0; req_cmd = 0;
        @(negedge clk);
        req_drv = 2; req_write = 1;   // held while busy
        @(negedge clk);
        req = 0;
        reg_we = 1; reg_op = 2; reg_drv = 0; reg_wdata = 8'h11;
        @(negedge clk);
        reg_we = 0;
        while (cur[3]) @(negedge clk);
        run(0, 0, 0, "R11");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule